// File: doc/BRIEF.md
# Dual-Channel Selectable-Ratio Half-Band Interpolator

This block raises the sample rate of two signed 10-bit channels by one, two or four before they reach a pair of DAC cores. It runs on the DAC-rate clock. Input samples arrive with a one-cycle valid strobe once every R clock cycles, where R is the selected ratio. Each input strobe produces R output samples on each channel, and each output sample is marked by an output valid strobe.

Two stage-enable inputs choose the ratio. The first half-band stage doubles the rate. The second stage, cascaded behind it, doubles the rate again. When neither stage is active, samples pass through a single register with no arithmetic.

Each stage inserts a zero between samples and filters with a seven-tap half-band kernel (-1, 0, 9, 16, 9, 0, -1)/16. The result is computed in polyphase form. A centre-phase output repeats a delayed sample. A midpoint output is rounded and clipped to the 10-bit range.

If the selected ratio changes, both stages clear their history, so samples from the old ratio and the new ratio never combine.

Top module: `interp_top`

## Requirements
- R1: While reset is held, and after it, `out_valid` is 0 and `out_a`/`out_b` are 0.
- R2: The ratio is decoded from the enables. `en_stage1`=0 selects 1x whatever `en_stage2` is. `en_stage1`=1 with `en_stage2`=0 selects 2x. Both enables at 1 select 4x.
- R3: In 1x, a sample accepted with `in_valid` at one clock edge appears on the outputs with `out_valid`=1 right after the next edge, unchanged.
- R4: A half-band stage handles each accepted sample x[k] as follows. Its first output is x[k-2], the centre phase. Its second output is the midpoint of x[k-1], x[k-2], x[k] and x[k-3]. Samples before the start of history count as 0.
- R5: The midpoint value is floor((9*(x[k-1]+x[k-2]) - (x[k]+x[k-3]) + 8) / 16), which is rounding to nearest with halves going up.
- R6: Every filtered output is clipped to the range -512..511.
- R7: In 2x, one stage runs on inputs spaced 2 cycles apart, and its two outputs come on consecutive cycles.
- R8: In 4x, the first stage's output stream, spaced 2 cycles apart, feeds the second stage, and the output carries the second stage's stream.
- R9: Any change of the decoded ratio does three things. It drops a sample presented in the cycle of the change. It clears all history to zero. It holds `out_valid` low after the next edge.
- R10: Both channels use the same ratio and timing, and each channel's values depend only on that channel's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe, one cycle in R |
| in_a | input | 10 | Channel A input sample, signed |
| in_b | input | 10 | Channel B input sample, signed |
| en_stage1 | input | 1 | Enables the first doubling stage |
| en_stage2 | input | 1 | Enables the second doubling stage (used only with the first) |
| out_valid | output | 1 | Output sample strobe |
| out_a | output | 10 | Channel A output sample, signed |
| out_b | output | 10 | Channel B output sample, signed |

## Verification
A ratio change and an input strobe can fall in the same clock cycle, and the flush must take priority over accepting the sample. The bench provokes this by raising `en_stage2` in the very cycle that presents a distinctive sample during 2x operation. It then checks that `out_valid` is low one edge later. It also checks that the following 4x output stream matches a model fed only the samples sent after the change, starting from zero history. Saturation and rounding also meet in one cycle: full-scale alternating patterns drive the midpoint past the 10-bit range, and the clipped values are compared with the bench's own arithmetic.

// File: rtl/interp_pkg.sv
package interp_pkg;
    localparam int SW   = 10;
    localparam int ACCW = SW + 6;
    localparam int SMAX = (2 ** (SW - 1)) - 1;
    localparam int SMIN = -(2 ** (SW - 1));
    localparam int LINE = 4;

    typedef logic signed [SW-1:0]   samp_t;
    typedef logic signed [ACCW-1:0] acc_t;

    typedef enum logic [1:0] {
        MODE_1X = 2'd0,
        MODE_2X = 2'd1,
        MODE_4X = 2'd2
    } mode_e;

    function automatic acc_t mid_sum(input samp_t d0, input samp_t d1,
                                     input samp_t d2, input samp_t d3);
        acc_t inner;
        acc_t outer;
        inner = acc_t'(d1) + acc_t'(d2);
        outer = acc_t'(d0) + acc_t'(d3);
        return (acc_t'(9) * inner) - outer;
    endfunction

    function automatic samp_t round_sat(input acc_t s);
        acc_t r;
        r = (s + acc_t'(8)) >>> 4;
        if (r > acc_t'(SMAX))      return samp_t'(SMAX);
        else if (r < acc_t'(SMIN)) return samp_t'(SMIN);
        else                       return r[SW-1:0];
    endfunction
endpackage

// File: rtl/hb_stage.sv
module hb_stage
    import interp_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  in_vld,
    input  logic  wide,
    input  samp_t in_s  [NCH],
    output logic  out_vld,
    output samp_t out_s [NCH]
);
    samp_t      line_q [NCH][LINE];
    logic [1:0] wait_q;
    samp_t      ch0_d1;

    assign ch0_d1 = line_q[0][1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_vld <= 1'b0;
            wait_q  <= 2'd0;
            for (int c = 0; c < NCH; c++) begin
                out_s[c] <= '0;
                for (int t = 0; t < LINE; t++) line_q[c][t] <= '0;
            end
        end else if (in_vld) begin
            out_vld <= 1'b1;
            wait_q  <= wide ? 2'd2 : 2'd1;
            for (int c = 0; c < NCH; c++) begin
                line_q[c][0] <= in_s[c];
                for (int t = 1; t < LINE; t++) line_q[c][t] <= line_q[c][t-1];
                out_s[c] <= line_q[c][1];
            end
        end else begin
            out_vld <= 1'b0;
            if (wait_q == 2'd1) begin
                out_vld <= 1'b1;
                wait_q  <= 2'd0;
                for (int c = 0; c < NCH; c++)
                    out_s[c] <= round_sat(mid_sum(line_q[c][0], line_q[c][1],
                                                  line_q[c][2], line_q[c][3]));
            end else if (wait_q == 2'd2) begin
                wait_q <= 2'd1;
            end
        end
    end

    AST_CENTER_PHASE: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !clr) |=> (out_vld && out_s[0] == $past(ch0_d1))) // R4
        else $error("centre phase mismatch");

    AST_MID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!in_vld && !clr && wait_q == 2'd1) |=> out_vld) // R7
        else $error("midpoint output missing");
endmodule

// File: rtl/interp_top.sv
module interp_top
    import interp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [SW-1:0] in_a,
    input  logic [SW-1:0] in_b,
    input  logic          en_stage1,
    input  logic          en_stage2,
    output logic          out_valid,
    output logic [SW-1:0] out_a,
    output logic [SW-1:0] out_b
);
    localparam int NCH = 2;

    mode_e mode_now, mode_q;
    logic  flush;

    always_comb begin
        if (!en_stage1)      mode_now = MODE_1X;
        else if (!en_stage2) mode_now = MODE_2X;
        else                 mode_now = MODE_4X;
    end

    assign flush = (mode_now != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_1X;
        else     mode_q <= mode_now;
    end

    samp_t in_vec [NCH];
    assign in_vec[0] = samp_t'(in_a);
    assign in_vec[1] = samp_t'(in_b);

    // bypass register for 1x
    logic  byp_vld;
    samp_t byp_s [NCH];
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            byp_vld <= 1'b0;
            for (int c = 0; c < NCH; c++) byp_s[c] <= '0;
        end else begin
            byp_vld <= in_valid && (mode_q == MODE_1X);
            if (in_valid && mode_q == MODE_1X)
                for (int c = 0; c < NCH; c++) byp_s[c] <= in_vec[c];
        end
    end

    logic  s1_vld, s2_vld;
    samp_t s1_s [NCH];
    samp_t s2_s [NCH];

    hb_stage #(.NCH(NCH)) u_stage1 (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .in_vld (in_valid && (mode_q != MODE_1X)),
        .wide   (mode_q == MODE_4X),
        .in_s   (in_vec),
        .out_vld(s1_vld),
        .out_s  (s1_s)
    );

    hb_stage #(.NCH(NCH)) u_stage2 (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .in_vld (s1_vld && (mode_q == MODE_4X)),
        .wide   (1'b0),
        .in_s   (s1_s),
        .out_vld(s2_vld),
        .out_s  (s2_s)
    );

    always_comb begin
        case (mode_q)
            MODE_2X: begin
                out_valid = s1_vld;
                out_a = s1_s[0];
                out_b = s1_s[1];
            end
            MODE_4X: begin
                out_valid = s2_vld;
                out_a = s2_s[0];
                out_b = s2_s[1];
            end
            default: begin
                out_valid = byp_vld;
                out_a = byp_s[0];
                out_b = byp_s[1];
            end
        endcase
    end

    AST_BYPASS_LAT: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_1X && !flush && in_valid) |=>
            (out_valid && out_a == $past(in_a) && out_b == $past(in_b))) // R3
        else $error("bypass latency broken");

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid) // R9
        else $error("output after ratio change");
endmodule

// File: tb/interp_top_tb.sv
`timescale 1ns/1ps
module interp_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [9:0] in_a = '0, in_b = '0;
    logic en_stage1 = 1'b0, en_stage2 = 1'b0;
    logic out_valid;
    logic [9:0] out_a, out_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int got_a[$];
    int got_b[$];

    always #4 clk = ~clk;

    interp_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .en_stage1(en_stage1), .en_stage2(en_stage2),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            got_a.push_back(int'($signed(out_a)));
            got_b.push_back(int'($signed(out_b)));
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rs(input int s);
        int r;
        r = (s + 8) >>> 4;
        if (r > 511)  r = 511;
        if (r < -512) r = -512;
        return r;
    endfunction

    function automatic void hb_model(input int xin[$], ref int yout[$]);
        int h0 = 0, h1 = 0, h2 = 0, h3 = 0;
        yout.delete();
        foreach (xin[i]) begin
            h3 = h2; h2 = h1; h1 = h0; h0 = xin[i];
            yout.push_back(h2);
            yout.push_back(rs(9 * (h1 + h2) - (h0 + h3)));
        end
    endfunction

    task automatic set_mode(input logic e1, input logic e2);
        @(negedge clk);
        en_stage1 = e1;
        en_stage2 = e2;
        repeat (6) @(negedge clk);
        got_a.delete();
        got_b.delete();
    endtask

    task automatic drive(input int xa[$], input int xb[$], input int ratio, input bit lat1x);
        foreach (xa[i]) begin
            in_valid = 1'b1;
            in_a = 10'(xa[i]);
            in_b = 10'(xb[i]);
            @(negedge clk);
            in_valid = 1'b0;
            if (lat1x) begin
                check("R3 valid", int'(out_valid), 1);
                check("R3 data a", int'($signed(out_a)), xa[i]);
            end
            for (int w = 1; w < ratio; w++) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic compare(input string req, input int xa[$], input int xb[$], input int ratio);
        int ea[$];
        int eb[$];
        int ta[$];
        int tb[$];
        if (ratio == 1) begin
            ea = xa; eb = xb;
        end else begin
            hb_model(xa, ea);
            hb_model(xb, eb);
            if (ratio == 4) begin
                ta = ea; tb = eb;
                hb_model(ta, ea);
                hb_model(tb, eb);
            end
        end
        check({req, " count"}, got_a.size(), ea.size());
        foreach (ea[i]) begin
            if (i < got_a.size()) begin
                check({req, " chA"}, got_a[i], ea[i]);
                check({req, " chB R10"}, got_b[i], eb[i]);
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int xa[$];
        int xb[$];
        int lcg = 12345;

        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_a), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_b), 0);

        // ramp sweep in 1x, channel B independent pattern
        for (int i = -512; i < 512; i += 37) begin
            xa.push_back(i);
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            xb.push_back((lcg >>> 8) % 512);
        end
        set_mode(1'b0, 1'b0);
        drive(xa, xb, 1, 1'b1);
        compare("R3 1x", xa, xb, 1);

        // en_stage2 alone is ignored: still 1x, no flush
        @(negedge clk);
        en_stage2 = 1'b1;
        @(negedge clk);
        got_a.delete(); got_b.delete();
        drive(xa, xb, 1, 1'b1);
        compare("R2 en2 ignored", xa, xb, 1);

        // 2x with ramp and random
        set_mode(1'b1, 1'b0);
        drive(xa, xb, 2, 1'b0);
        compare("R4 R5 R7 2x", xa, xb, 2);

        // saturation patterns in 2x
        xa.delete(); xb.delete();
        for (int i = 0; i < 24; i++) begin
            xa.push_back(((i / 2) % 2 == 0) ? 511 : -512);
            xb.push_back(((i / 2) % 2 == 0) ? -512 : 511);
        end
        set_mode(1'b0, 1'b0);
        set_mode(1'b1, 1'b0);
        drive(xa, xb, 2, 1'b0);
        compare("R6 2x sat", xa, xb, 2);
        if (got_a.size() > 5) check("R6 clip high", got_a[5], 511);

        // 4x with sat patterns
        set_mode(1'b1, 1'b1);
        drive(xa, xb, 4, 1'b0);
        compare("R8 R6 4x", xa, xb, 4);

        // 4x with mixed values
        xa.delete(); xb.delete();
        for (int i = 0; i < 40; i++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            xa.push_back(((lcg >>> 4) % 1024) - 512);
            xb.push_back((i * 53) % 1024 - 512);
        end
        set_mode(1'b1, 1'b0);
        set_mode(1'b1, 1'b1);
        drive(xa, xb, 4, 1'b0);
        compare("R8 4x", xa, xb, 4);

        // ratio change coinciding with input strobe
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_a = 10'(100 + i); in_b = 10'(-100 - i);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b1; in_a = 10'(300); in_b = 10'(-300);
        en_stage2 = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 quiet after change", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        got_a.delete(); got_b.delete();
        xa.delete(); xb.delete();
        for (int i = 0; i < 12; i++) begin
            xa.push_back(40 * i - 200);
            xb.push_back(-30 * i + 150);
        end
        drive(xa, xb, 4, 1'b0);
        compare("R9 fresh history", xa, xb, 4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule